// File: doc/BRIEF.md
# I2C Slave Byte Loader with Running Target Address

This block sits on a two-wire bus as a slave device and turns incoming write traffic into a stream of byte writes for a downstream memory loader. It samples the bus clock and data lines with its own system clock, so the system clock must be several times faster than SCL. It finds START and STOP conditions and decodes the address byte. The device answers to a 7-bit address made of a fixed six-bit prefix `011010` and one strap bit. It also answers to the general-call address in the write direction. SDA is driven through an open-drain enable (`sda_oe` high pulls the line low).

A single target-address pointer is kept across bus frames. In a write frame addressed to the device's own address, the first data byte is a sub-address that sets the pointer. This gives random access. A write frame sent to the general-call address has no sub-address: its bytes go straight to the running pointer, continuing from where the last frame ended. This gives sequential access across frames. Every stored byte appears as a one-cycle strobe with its address and data, and the pointer then advances by one. A read, for example after a repeated START, returns bytes from the pointer location MSB first. The memory is presented on `rd_addr`/`rd_data`, and the pointer advances after each byte sent.

Top module: `i2c_autoinc_slave`

## Requirements
- R1: After synchronous reset, `sda_oe` and `wr_en` are low and the pointer (`rd_addr`) is 0.
- R2: The own address is `{011010, strap_sel}` and is acknowledged in either direction. Any other address byte, except general call write, is not acknowledged. The rest of that frame is ignored: no ACK, no write, and no pointer change until the next START.
- R3: Address byte 00h (general call, write) is acknowledged. Address byte 01h (general call with read bit set) is not acknowledged.
- R4: In a write frame to the own address, the first data byte is acknowledged and loads the pointer. It produces no write strobe.
- R5: Each further data byte is acknowledged and produces exactly one one-cycle `wr_en` pulse, with `wr_addr` equal to the pointer and `wr_data` equal to the byte. The pointer then increments, so the bytes of a frame land at ascending addresses in bus order.
- R6: In a general-call write frame, every data byte is stored at the running pointer. Storage continues from the address that follows the last byte of the previous frame.
- R7: The pointer wraps from 2^ADDR_W-1 to 0.
- R8: In a read frame, each byte is `rd_data` at the current pointer, sent MSB first, and the pointer increments after each byte. A master ACK continues the read; a master NACK ends it.
- R9: The slave pulls SDA low for an ACK only from the SCL falling edge after the 8th bit to the falling edge after the 9th. It releases SDA on a STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| strap_sel | input | 1 | Static strap giving the low address bit (0 when unconnected) |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_oe | output | 1 | Open-drain enable: 1 pulls SDA low |
| wr_en | output | 1 | One-cycle write strobe to the loader |
| wr_addr | output | ADDR_W | Target address of the stored byte |
| wr_data | output | 8 | Stored byte |
| rd_addr | output | ADDR_W | Current pointer, used as the read address |
| rd_data | input | 8 | Byte at `rd_addr`, sampled on SCL falling edges |

## Verification
The hardest situation to reach is a pointer that must survive a frame boundary and a change of access mode. Examples are a general-call frame that continues a previous frame, and a sub-addressed read whose post-increments must be seen by the next write frame. The bench's bus master chains these frames back to back. The scoreboard holds the expected address of every stored byte, so any restart or skipped increment appears as an address mismatch. Rejected address bytes followed by data, and a sub-address of FFh, drive the ignore path and the wrap.

// File: rtl/i2c_slv_pkg.sv
package i2c_slv_pkg;
  localparam logic [5:0] DEV_PREFIX = 6'b011010;
  localparam logic [7:0] GEN_CALL_W = 8'h00;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_END,
    ST_ACK,
    ST_WR,
    ST_WR_END,
    ST_RD,
    ST_RD_MACK
  } slv_state_t;
endpackage

// File: rtl/i2c_slv_sync.sv
module i2c_slv_sync #(
  parameter int LINES  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LINES-1:0] din,
  output logic [LINES-1:0] cur,
  output logic [LINES-1:0] prev
);
  generate
    for (genvar i = 0; i < LINES; i++) begin : g_line
      logic [STAGES-1:0] pipe;
      always_ff @(posedge clk) begin
        if (rst) pipe <= '1;
        else     pipe <= {pipe[STAGES-2:0], din[i]};
      end
      assign cur[i] = pipe[STAGES-1];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev <= '1;
    else     prev <= cur;
  end
endmodule

// File: rtl/i2c_slv_ptr.sv
module i2c_slv_ptr #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_val,
  input  logic              inc,
  output logic [ADDR_W-1:0] ptr
);
  always_ff @(posedge clk) begin
    if (rst)       ptr <= '0;
    else if (load) ptr <= load_val;
    else if (inc)  ptr <= ptr + 1'b1;
  end

  p_wrap_r7: assert property (@(posedge clk) disable iff (rst)
    (inc && !load && ptr == '1) |=> (ptr == '0));
endmodule

// File: rtl/i2c_autoinc_slave.sv
module i2c_autoinc_slave
  import i2c_slv_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              strap_sel,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [7:0]        rd_data
);
  localparam int BIT_W = 3;
  localparam logic [BIT_W-1:0] LAST_BIT = 3'd7;

  logic [1:0] ln_cur, ln_prev;
  logic scl_s, scl_p, sda_s, sda_p;
  logic scl_rise, scl_fall, start_det, stop_det;

  i2c_slv_sync #(.LINES(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .din({scl_i, sda_i}), .cur(ln_cur), .prev(ln_prev)
  );

  assign scl_s = ln_cur[1];
  assign sda_s = ln_cur[0];
  assign scl_p = ln_prev[1];
  assign sda_p = ln_prev[0];

  assign scl_rise  = scl_s & ~scl_p;
  assign scl_fall  = ~scl_s & scl_p;
  assign start_det = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;

  slv_state_t       state;
  logic [BIT_W-1:0] bit_cnt;
  logic [7:0]       sh, tx;
  logic             rw_q, sub_pend, mack_q;
  logic             own_hit, gc_hit;
  logic             ptr_load, ptr_inc;
  logic [ADDR_W-1:0] ptr_val;

  assign own_hit = (sh[7:1] == {DEV_PREFIX, strap_sel});
  assign gc_hit  = (sh == GEN_CALL_W);

  always_comb begin
    ptr_load = (state == ST_WR_END) && scl_fall && sub_pend && !start_det && !stop_det;
    ptr_inc  = ((state == ST_WR_END) && scl_fall && !sub_pend && !start_det && !stop_det) ||
               ((state == ST_RD) && scl_fall && (bit_cnt == LAST_BIT) && !start_det && !stop_det);
    ptr_val  = ADDR_W'(sh);
  end

  i2c_slv_ptr #(.ADDR_W(ADDR_W)) u_ptr (
    .clk(clk), .rst(rst), .load(ptr_load), .load_val(ptr_val),
    .inc(ptr_inc), .ptr(rd_addr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      bit_cnt  <= '0;
      sh       <= '0;
      tx       <= '0;
      rw_q     <= 1'b0;
      sub_pend <= 1'b0;
      mack_q   <= 1'b0;
      sda_oe   <= 1'b0;
      wr_en    <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
    end else begin
      wr_en <= 1'b0;
      if (start_det) begin
        state   <= ST_ADDR;
        bit_cnt <= '0;
        sda_oe  <= 1'b0;
      end else if (stop_det) begin
        state  <= ST_IDLE;
        sda_oe <= 1'b0;
      end else begin
        case (state)
          ST_ADDR, ST_WR: if (scl_rise) begin
            sh      <= {sh[6:0], sda_s};
            bit_cnt <= bit_cnt + 1'b1;
            if (bit_cnt == LAST_BIT)
              state <= (state == ST_ADDR) ? ST_ADDR_END : ST_WR_END;
          end
          ST_ADDR_END: if (scl_fall) begin
            if (own_hit || gc_hit) begin
              sda_oe   <= 1'b1;
              rw_q     <= sh[0];
              sub_pend <= own_hit;
              state    <= ST_ACK;
            end else begin
              state <= ST_IDLE;
            end
          end
          ST_WR_END: if (scl_fall) begin
            sda_oe   <= 1'b1;
            sub_pend <= 1'b0;
            state    <= ST_ACK;
            if (!sub_pend) begin
              wr_en   <= 1'b1;
              wr_addr <= rd_addr;
              wr_data <= sh;
            end
          end
          ST_ACK: if (scl_fall) begin
            bit_cnt <= '0;
            if (rw_q) begin
              tx     <= rd_data;
              sda_oe <= ~rd_data[7];
              state  <= ST_RD;
            end else begin
              sda_oe <= 1'b0;
              state  <= ST_WR;
            end
          end
          ST_RD: if (scl_fall) begin
            bit_cnt <= bit_cnt + 1'b1;
            if (bit_cnt == LAST_BIT) begin
              sda_oe <= 1'b0;
              mack_q <= 1'b0;
              state  <= ST_RD_MACK;
            end else begin
              tx     <= {tx[6:0], 1'b0};
              sda_oe <= ~tx[6];
            end
          end
          ST_RD_MACK: begin
            if (scl_rise) mack_q <= ~sda_s;
            if (scl_fall) begin
              if (mack_q) begin
                tx      <= rd_data;
                sda_oe  <= ~rd_data[7];
                bit_cnt <= '0;
                state   <= ST_RD;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  p_strobe_single_r5: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> !wr_en);

  p_ptr_step_r5: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (rd_addr == ADDR_W'(wr_addr + 1'b1)));

  p_release_on_stop_r9: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> !sda_oe);

  p_nack_foreign_r2: assert property (@(posedge clk) disable iff (rst)
    ((state == ST_ADDR_END) && scl_fall && !own_hit && !gc_hit && !start_det && !stop_det)
      |=> (!sda_oe && state == ST_IDLE));

  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE) |-> !sda_oe);
endmodule

// File: tb/tb_i2c_autoinc_slave.sv
module tb_i2c_autoinc_slave;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 8;
  localparam int Q          = 4;
  localparam int WATCHDOG   = 150000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic strap_sel = 1'b0;
  logic m_scl = 1'b1;
  logic m_sda_low = 1'b0;
  logic sda_bus;
  logic sda_oe, wr_en;
  logic [ADDR_W-1:0] wr_addr, rd_addr;
  logic [7:0] wr_data, rd_data;
  logic [7:0] mem [0:(1<<ADDR_W)-1];

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  typedef struct packed { logic [ADDR_W-1:0] a; logic [7:0] d; } wr_item_t;
  wr_item_t exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  assign sda_bus = ~(m_sda_low | sda_oe);
  assign rd_data = mem[rd_addr];

  i2c_autoinc_slave #(.ADDR_W(ADDR_W)) dut (
    .clk(clk), .rst(rst), .strap_sel(strap_sel), .scl_i(m_scl), .sda_i(sda_bus),
    .sda_oe(sda_oe), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push_wr(input logic [ADDR_W-1:0] a, input logic [7:0] d);
    wr_item_t it;
    it.a = a;
    it.d = d;
    exp_q.push_back(it);
  endtask

  // Monitor: stores into the bench memory and compares with the scoreboard.
  always @(negedge clk) begin
    if (!rst && wr_en) begin
      mem[wr_addr] = wr_data;
      if (exp_q.size() == 0) begin
        check(1'b0, "R2/R5 unexpected write strobe", int'(wr_addr), 0);
      end else begin
        wr_item_t it;
        it = exp_q.pop_front();
        check(wr_addr == it.a, "R5 write address", int'(wr_addr), int'(it.a));
        check(wr_data == it.d, "R5 write data", int'(wr_data), int'(it.d));
      end
    end
  end

  task automatic bus_start;
    m_sda_low = 1'b0; tick(Q);
    m_scl = 1'b1;     tick(Q);
    m_sda_low = 1'b1; tick(Q);
    m_scl = 1'b0;     tick(Q);
  endtask

  task automatic bus_stop;
    m_sda_low = 1'b1; tick(Q);
    m_scl = 1'b1;     tick(Q);
    m_sda_low = 1'b0; tick(Q);
  endtask

  task automatic write_byte(input logic [7:0] b, input bit chk_rel, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda_low = ~b[i]; tick(Q);
      m_scl = 1'b1;      tick(Q);
      if (i == 0) check(sda_bus == b[0], "R9 no early ACK drive", int'(sda_bus), int'(b[0]));
      tick(Q);
      m_scl = 1'b0;      tick(Q);
    end
    m_sda_low = 1'b0; tick(Q);
    m_scl = 1'b1;     tick(Q);
    ack = ~sda_bus;   tick(Q);
    m_scl = 1'b0;     tick(Q);
    if (chk_rel) check(sda_oe == 1'b0, "R9 release after ACK clock", int'(sda_oe), 0);
  endtask

  task automatic read_byte(input logic mack, output logic [7:0] b);
    m_sda_low = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      tick(Q);
      m_scl = 1'b1; tick(Q);
      b[i] = sda_bus; tick(Q);
      m_scl = 1'b0;
    end
    tick(Q);
    m_sda_low = mack; tick(Q);
    m_scl = 1'b1;     tick(2*Q);
    m_scl = 1'b0;     tick(Q);
    m_sda_low = 1'b0;
  endtask

  task automatic report;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=0 expected=1");
      report();
      $finish;
    end
  end

  initial begin
    logic ack;
    logic [7:0] rb;
    for (int i = 0; i < (1<<ADDR_W); i++) mem[i] = 8'h00;
    tick(5);
    check(sda_oe == 1'b0, "R1 sda_oe reset", int'(sda_oe), 0);
    check(wr_en == 1'b0, "R1 wr_en reset", int'(wr_en), 0);
    check(rd_addr == '0, "R1 pointer reset", int'(rd_addr), 0);
    rst = 1'b0;
    tick(10);

    // Frame 1: own address, sub-address 10h, three bytes
    bus_start();
    write_byte(8'h68, 1'b1, ack); check(ack, "R2 own address ACK", int'(ack), 1);
    write_byte(8'h10, 1'b1, ack); check(ack, "R4 sub-address ACK", int'(ack), 1);
    check(rd_addr == 8'h10, "R4 pointer loaded", int'(rd_addr), 'h10);
    push_wr(8'h10, 8'hA0); push_wr(8'h11, 8'hA1); push_wr(8'h12, 8'hA2);
    write_byte(8'hA0, 1'b1, ack); check(ack, "R5 data ACK", int'(ack), 1);
    write_byte(8'hA1, 1'b1, ack); check(ack, "R5 data ACK", int'(ack), 1);
    write_byte(8'hA2, 1'b1, ack); check(ack, "R5 data ACK", int'(ack), 1);
    bus_stop();
    check(sda_oe == 1'b0, "R9 released after STOP", int'(sda_oe), 0);

    // Frame 2: general call continues at 13h
    bus_start();
    write_byte(8'h00, 1'b1, ack); check(ack, "R3 general call ACK", int'(ack), 1);
    push_wr(8'h13, 8'hB0); push_wr(8'h14, 8'hB1);
    write_byte(8'hB0, 1'b1, ack); check(ack, "R6 data ACK", int'(ack), 1);
    write_byte(8'hB1, 1'b1, ack); check(ack, "R6 data ACK", int'(ack), 1);
    bus_stop();

    // Foreign address: NACK and the following byte is ignored
    bus_start();
    write_byte(8'h6A, 1'b0, ack); check(!ack, "R2 foreign address NACK", int'(ack), 0);
    write_byte(8'h55, 1'b0, ack); check(!ack, "R2 ignored byte NACK", int'(ack), 0);
    bus_stop();
    check(rd_addr == 8'h15, "R2 pointer untouched", int'(rd_addr), 'h15);

    // General call with read bit
    bus_start();
    write_byte(8'h01, 1'b0, ack); check(!ack, "R3 general call read NACK", int'(ack), 0);
    bus_stop();

    // Strap high moves the own address to 35h
    strap_sel = 1'b1; tick(4);
    bus_start();
    write_byte(8'h6A, 1'b1, ack); check(ack, "R2 strap address ACK", int'(ack), 1);
    write_byte(8'h20, 1'b1, ack);
    push_wr(8'h20, 8'hC0);
    write_byte(8'hC0, 1'b1, ack); check(ack, "R5 data ACK strap", int'(ack), 1);
    bus_stop();
    bus_start();
    write_byte(8'h68, 1'b0, ack); check(!ack, "R2 old address NACK with strap", int'(ack), 0);
    bus_stop();
    strap_sel = 1'b0; tick(4);

    // Random read: sub-address then repeated START with read
    bus_start();
    write_byte(8'h68, 1'b1, ack);
    write_byte(8'h10, 1'b1, ack);
    bus_start();
    write_byte(8'h69, 1'b0, ack); check(ack, "R8 read address ACK", int'(ack), 1);
    read_byte(1'b1, rb); check(rb == 8'hA0, "R8 read byte 0", int'(rb), 'hA0);
    read_byte(1'b1, rb); check(rb == 8'hA1, "R8 read byte 1", int'(rb), 'hA1);
    read_byte(1'b0, rb); check(rb == 8'hA2, "R8 read byte 2", int'(rb), 'hA2);
    bus_stop();
    check(rd_addr == 8'h13, "R8 pointer after reads", int'(rd_addr), 'h13);

    // General call after read continues at 13h
    bus_start();
    write_byte(8'h00, 1'b1, ack);
    push_wr(8'h13, 8'hD0);
    write_byte(8'hD0, 1'b1, ack); check(ack, "R6 continue after read", int'(ack), 1);
    bus_stop();

    // Wrap at the top of the address space
    bus_start();
    write_byte(8'h68, 1'b1, ack);
    write_byte(8'hFF, 1'b1, ack);
    push_wr(8'hFF, 8'hE0); push_wr(8'h00, 8'hE1);
    write_byte(8'hE0, 1'b1, ack);
    write_byte(8'hE1, 1'b1, ack); check(ack, "R7 wrapped byte ACK", int'(ack), 1);
    bus_stop();
    check(rd_addr == 8'h01, "R7 pointer after wrap", int'(rd_addr), 1);

    tick(10);
    check(exp_q.size() == 0, "R5 all expected writes seen", exp_q.size(), 0);
    finished = 1'b1;
    report();
    $finish;
  end
endmodule